// File: doc/BRIEF.md
# Three-Phase PWM Command Timing Guard

This block sits between a PWM generator and a three-phase half-bridge driver. Each phase has a high-side and a low-side active-high command. The block lets a command through only when its timing is safe. A command that breaks a rule is suppressed and never reaches the driver. The rules are:

- both switches of a leg are never commanded on together;
- a switch turns on only after its partner has been off for a dead interval;
- an on pulse and the off gap before it each last at least a minimum width;
- successive turn-ons of one switch are separated by at least one PWM period.

The block does not create dead time. It checks the dead time that the generator supplied.

Every rule has one sticky error flag per phase. A synchronous clear input resets the flags. A falling command reaches the gate after one clock. A rising command reaches the gate only once the command has proved its minimum width. All limits are parameters counted in clock cycles.

Top module: `pwm_guard`

## Requirements
- R1: In any phase, `gate_hi[p]` and `gate_lo[p]` are never high in the same cycle.
- R2: When `cmd_hi[p]` and `cmd_lo[p]` are sampled high on the same edge, both gates of phase p are low after that edge and `err_ovl[p]` is set.
- R3: A command sampled low drives its gate low after that same edge, which is a latency of one clock.
- R4: A gate rises on the edge that samples its command high for the MIN_ON_CYC-th consecutive time, provided that every check passes. A high pulse shorter than MIN_ON_CYC cycles never reaches the gate and sets `err_width[p]`.
- R5: A high pulse that follows a low gap shorter than MIN_OFF_CYC cycles is suppressed and sets `err_width[p]`.
- R6: A gate rises only if the partner gate of the same phase has been low for at least DEAD_CYC cycles, counting the decision cycle. Otherwise the pulse is suppressed and `err_dead[p]` is set.
- R7: Two rises of the same gate are at least PERIOD_CYC cycles apart. A pulse that would rise sooner is suppressed and sets `err_rate[p]`.
- R8: After a pulse has been suppressed or cut by an overlap, the gate stays low until its command has been low and rises again. The guard is edge-triggered, so it never re-fires during a held command.
- R9: The error flags hold their value until `clr` is sampled high, and they clear on that edge. A violation on the same edge as the clear still sets its flag.
- R10: After reset, all gates and flags are low. The first pulse after reset is not limited by the gap, dead-time or rate rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of all error flags |
| cmd_hi | input | NPH | High-side commands, with bit p for phase p |
| cmd_lo | input | NPH | Low-side commands, with bit p for phase p |
| gate_hi | output | NPH | Checked high-side gate commands |
| gate_lo | output | NPH | Checked low-side gate commands |
| err_ovl | output | NPH | Sticky flag: both commands of phase p were high together |
| err_dead | output | NPH | Sticky flag: dead-time violation in phase p |
| err_width | output | NPH | Sticky flag: short pulse or short gap in phase p |
| err_rate | output | NPH | Sticky flag: turn-on rate exceeded in phase p |

## Verification
The assertions check the following on every cycle:

- the two gates of a leg are never both high;
- an overlap forces both gates low and sets its flag;
- the one-clock fall latency;
- a gate rises only if its command was high and its partner gate was low;
- the flags stay set until cleared.

Only the bench scenarios can show the rest. This covers the exact turn-on cycle after MIN_ON_CYC samples, the suppression of short pulses and short gaps, the dead-time window in both its failing and its passing case, and the rate limit. It also covers the edge-triggered lockout over a held command and the fact that a violation wins over a clear in the same cycle.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  typedef struct packed {
    logic ovl;
    logic dead;
    logic width;
    logic rate;
  } viol_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pwm_guard_chan.sv
module pwm_guard_chan
  import pwm_guard_pkg::*;
#(
  parameter int CW      = 8,
  parameter int MIN_ON  = 4,
  parameter int MIN_OFF = 4,
  parameter int DEAD    = 4,
  parameter int PERIOD  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd,
  input  logic  peer_cmd,
  input  logic  peer_idle,
  output logic  gate,
  output logic  idle,
  output viol_t viol
);
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] ON_L    = CW'(MIN_ON);
  localparam logic [CW-1:0] OFF_L   = CW'(MIN_OFF);
  localparam logic [CW-1:0] DEAD_L  = CW'(DEAD);
  localparam logic [CW-1:0] RATE_L  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic          prev_q, gate_q, lock_q, gap_ok_q;
  logic [CW-1:0] run_q, on_age_q, off_age_q;
  logic          gate_d, lock_d, gap_ok_d;
  logic [CW-1:0] run_d, on_age_d, off_age_d;

  logic ovl, rise, fall, gap_now, decide, rate_ok, accept, reject;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + ONE;
  endfunction

  always_comb begin
    ovl     = cmd & peer_cmd;
    rise    = cmd & ~prev_q;
    fall    = ~cmd & prev_q;
    run_d   = (cmd == prev_q) ? sat_inc(run_q) : ONE;
    gap_now = rise ? (run_q >= OFF_L) : gap_ok_q;
    rate_ok = on_age_q >= RATE_L;
    decide  = cmd & ~gate_q & ~lock_q & ~ovl & (run_d == ON_L);
    accept  = decide & gap_now & peer_idle & rate_ok;
    reject  = decide & ~accept;

    gate_d    = cmd & ~ovl & (gate_q | accept);
    lock_d    = cmd & (lock_q | ovl | reject);
    gap_ok_d  = gap_now;
    on_age_d  = (gate_d & ~gate_q) ? '0 : sat_inc(on_age_q);
    off_age_d = gate_d ? '0 : sat_inc(off_age_q);

    viol.ovl   = ovl;
    viol.dead  = reject & ~peer_idle;
    viol.width = (reject & ~gap_now) | (fall & ~gate_q & ~lock_q);
    viol.rate  = reject & ~rate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      gate_q    <= 1'b0;
      lock_q    <= 1'b0;
      gap_ok_q  <= 1'b1;
      run_q     <= CMAX;
      on_age_q  <= CMAX;
      off_age_q <= CMAX;
    end else begin
      prev_q    <= cmd;
      gate_q    <= gate_d;
      lock_q    <= lock_d;
      gap_ok_q  <= gap_ok_d;
      run_q     <= run_d;
      on_age_q  <= on_age_d;
      off_age_q <= off_age_d;
    end
  end

  assign gate = gate_q;
  assign idle = off_age_q >= DEAD_L;

endmodule

// File: rtl/pwm_guard_flags.sv
module pwm_guard_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = (flags_q & {W{~clr}}) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import pwm_guard_pkg::*;
#(
  parameter int NPH         = 3,
  parameter int DEAD_CYC    = 250,
  parameter int MIN_ON_CYC  = 300,
  parameter int MIN_OFF_CYC = 300,
  parameter int PERIOD_CYC  = 12500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NPH-1:0] cmd_hi,
  input  logic [NPH-1:0] cmd_lo,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic [NPH-1:0] err_ovl,
  output logic [NPH-1:0] err_dead,
  output logic [NPH-1:0] err_width,
  output logic [NPH-1:0] err_rate
);
  localparam int MAXL = max4(DEAD_CYC, MIN_ON_CYC, MIN_OFF_CYC, PERIOD_CYC);
  localparam int CW   = $clog2(MAXL + 1);
  localparam int FW   = 4 * NPH;

  logic [NPH-1:0] idle_hi, idle_lo;
  logic [NPH-1:0] s_ovl, s_dead, s_width, s_rate;
  viol_t          v_hi [NPH];
  viol_t          v_lo [NPH];
  logic [FW-1:0]  flag_vec;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    pwm_guard_chan #(
      .CW(CW), .MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC),
      .DEAD(DEAD_CYC), .PERIOD(PERIOD_CYC)
    ) u_hi (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_hi[p]), .peer_cmd(cmd_lo[p]),
      .peer_idle(idle_lo[p]), .gate(gate_hi[p]), .idle(idle_hi[p]), .viol(v_hi[p])
    );
    pwm_guard_chan #(
      .CW(CW), .MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC),
      .DEAD(DEAD_CYC), .PERIOD(PERIOD_CYC)
    ) u_lo (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_lo[p]), .peer_cmd(cmd_hi[p]),
      .peer_idle(idle_hi[p]), .gate(gate_lo[p]), .idle(idle_lo[p]), .viol(v_lo[p])
    );
    assign s_ovl[p]   = v_hi[p].ovl   | v_lo[p].ovl;
    assign s_dead[p]  = v_hi[p].dead  | v_lo[p].dead;
    assign s_width[p] = v_hi[p].width | v_lo[p].width;
    assign s_rate[p]  = v_hi[p].rate  | v_lo[p].rate;
  end

  pwm_guard_flags #(.W(FW)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .set({s_rate, s_width, s_dead, s_ovl}),
    .flags(flag_vec)
  );

  assign err_ovl   = flag_vec[NPH-1:0];
  assign err_dead  = flag_vec[2*NPH-1:NPH];
  assign err_width = flag_vec[3*NPH-1:2*NPH];
  assign err_rate  = flag_vec[4*NPH-1:3*NPH];

endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic [NPH-1:0] cmd_hi,
  input logic [NPH-1:0] cmd_lo,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic [NPH-1:0] err_ovl,
  input logic [NPH-1:0] err_dead,
  input logic [NPH-1:0] err_width,
  input logic [NPH-1:0] err_rate
);
  for (genvar p = 0; p < NPH; p++) begin : g_chk
    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[p] && gate_lo[p])); // R1
    AST_OVL_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hi[p] && cmd_lo[p]) |=> (!gate_hi[p] && !gate_lo[p])); // R2
    AST_OVL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hi[p] && cmd_lo[p]) |=> err_ovl[p]); // R2
    AST_FALL_HI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_hi[p] |=> !gate_hi[p]); // R3
    AST_FALL_LO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_lo[p] |=> !gate_lo[p]); // R3
    AST_RISE_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[p]) |-> $past(cmd_hi[p])); // R4
    AST_RISE_PEER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[p]) |-> !$past(gate_hi[p])); // R6
    AST_HOLD_OVL: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovl[p] && !clr) |=> err_ovl[p]); // R9
    AST_HOLD_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_dead[p] && !clr) |=> err_dead[p]); // R9
    AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (err_width[p] && !clr) |=> err_width[p]); // R9
    AST_HOLD_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rate[p] && !clr) |=> err_rate[p]); // R9
  end
endmodule

bind pwm_guard pwm_guard_chk #(.NPH(NPH)) u_chk (.*);

// File: tb/sim_pwm_guard.sv
`timescale 1ns/1ps
module sim_pwm_guard;
  localparam int NPH = 3, DEAD = 6, MIN_ON = 4, MIN_OFF = 5, PERIOD = 24;

  logic clk = 1'b0, rst_n, clr;
  logic [NPH-1:0] cmd_hi, cmd_lo, gate_hi, gate_lo, err_ovl, err_dead, err_width, err_rate;

  pwm_guard #(.NPH(NPH), .DEAD_CYC(DEAD), .MIN_ON_CYC(MIN_ON),
              .MIN_OFF_CYC(MIN_OFF), .PERIOD_CYC(PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .err_ovl(err_ovl), .err_dead(err_dead),
    .err_width(err_width), .err_rate(err_rate));

  always #2 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit done = 0, mon_on = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model built on event timestamps (cycle numbers).
  int  tcyc;
  bit  m_prev[6], m_gate[6], m_lock[6], m_gapok[6];
  int  hi_st[6], lo_st[6], flc[6], rc[6];
  bit  n_prev[6], n_gate[6], n_lock[6], n_gapok[6];
  int  n_hi[6], n_lo[6];
  bit [NPH-1:0] mf_o, mf_d, mf_w, mf_r, vo, vd, vw, vr;

  function automatic bit cin(input int ch);
    return (ch % 2) ? cmd_lo[ch/2] : cmd_hi[ch/2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      tcyc = 0;
      for (int ch = 0; ch < 6; ch++) begin
        m_prev[ch] = 0; m_gate[ch] = 0; m_lock[ch] = 0; m_gapok[ch] = 1;
        hi_st[ch] = 0; lo_st[ch] = -100000; flc[ch] = -100000; rc[ch] = -100000;
      end
      mf_o = '0; mf_d = '0; mf_w = '0; mf_r = '0;
    end else begin
      vo = '0; vd = '0; vw = '0; vr = '0;
      for (int ch = 0; ch < 6; ch++) begin
        int p, pr, hrun;
        bit x, ovl, rise, fall, gapnow, dec, dok, rok, acc, rej;
        p = ch / 2; pr = ch ^ 1;
        x = cin(ch);
        ovl = x && cin(pr);
        rise = x && !m_prev[ch];
        fall = !x && m_prev[ch];
        gapnow = rise ? ((tcyc - lo_st[ch]) >= MIN_OFF) : m_gapok[ch];
        hrun = rise ? 1 : (tcyc - hi_st[ch] + 1);
        dec = x && !m_gate[ch] && !m_lock[ch] && !ovl && (hrun == MIN_ON);
        dok = !m_gate[pr] && ((tcyc - flc[pr] + 1) >= DEAD);
        rok = (tcyc + 1 - rc[ch]) >= PERIOD;
        acc = dec && gapnow && dok && rok;
        rej = dec && !acc;
        n_gate[ch]  = x && !ovl && (m_gate[ch] || acc);
        n_lock[ch]  = x && (m_lock[ch] || ovl || rej);
        n_gapok[ch] = gapnow;
        n_prev[ch]  = x;
        n_hi[ch] = rise ? tcyc : hi_st[ch];
        n_lo[ch] = fall ? tcyc : lo_st[ch];
        vo[p] |= ovl;
        vd[p] |= rej && !dok;
        vw[p] |= (rej && !gapnow) || (fall && !m_gate[ch] && !m_lock[ch]);
        vr[p] |= rej && !rok;
      end
      for (int ch = 0; ch < 6; ch++) begin
        if (m_gate[ch] && !n_gate[ch]) flc[ch] = tcyc + 1;
        if (!m_gate[ch] && n_gate[ch]) rc[ch] = tcyc + 1;
        m_gate[ch] = n_gate[ch]; m_lock[ch] = n_lock[ch]; m_gapok[ch] = n_gapok[ch];
        m_prev[ch] = n_prev[ch]; hi_st[ch] = n_hi[ch]; lo_st[ch] = n_lo[ch];
      end
      mf_o = (mf_o & {NPH{~clr}}) | vo;
      mf_d = (mf_d & {NPH{~clr}}) | vd;
      mf_w = (mf_w & {NPH{~clr}}) | vw;
      mf_r = (mf_r & {NPH{~clr}}) | vr;
      tcyc++;
    end
  end

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (mon_on && rst_n && !done) begin
      for (int p = 0; p < NPH; p++) begin
        chk("R1 no shoot-through", gate_hi[p] & gate_lo[p], 0);
        chk("R4 gate_hi vs model", gate_hi[p], m_gate[2*p]);
        chk("R4 gate_lo vs model", gate_lo[p], m_gate[2*p+1]);
        chk("R2 err_ovl vs model", err_ovl[p], mf_o[p]);
        chk("R6 err_dead vs model", err_dead[p], mf_d[p]);
        chk("R5 err_width vs model", err_width[p], mf_w[p]);
        chk("R7 err_rate vs model", err_rate[p], mf_r[p]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  int hold [NPH];
  int mode [NPH];

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr = 1'b0; cmd_hi = '0; cmd_lo = '0;
    step(5);
    rst_n = 1'b1;
    step(1);
    mon_on = 1;
    chk("R10 reset gates", {gate_hi, gate_lo}, 0);
    chk("R10 reset flags", {err_ovl, err_dead, err_width, err_rate}, 0);

    // R4 / R10: first pulse after reset, rise after MIN_ON samples
    cmd_hi[0] = 1'b1;
    step(MIN_ON - 1); chk("R4 not yet risen", gate_hi[0], 0);
    step(1);          chk("R4 rises on MIN_ON-th sample", gate_hi[0], 1);
    chk("R10 first pulse unrestricted", gate_hi[0], 1);
    step(5);
    cmd_hi[0] = 1'b0;
    step(1);          chk("R3 one-clock fall", gate_hi[0], 0);

    // R4: short pulse suppressed
    step(30);
    cmd_hi[1] = 1'b1; step(2);
    cmd_hi[1] = 1'b0; step(1);
    chk("R4 short pulse blocked", gate_hi[1], 0);
    step(1);
    chk("R4 short pulse flagged", err_width[1], 1);
    step(5);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R9 clear", err_width[1], 0);

    // R2 / R8 / R9: overlap together with clear, then held high-side
    step(30);
    cmd_hi[2] = 1'b1; cmd_lo[2] = 1'b1; clr = 1'b1;
    step(1); clr = 1'b0;
    chk("R2 overlap gates low", {gate_hi[2], gate_lo[2]}, 0);
    step(2); cmd_lo[2] = 1'b0;
    step(8);
    chk("R8 no re-trigger while held", gate_hi[2], 0);
    chk("R2 overlap flag", err_ovl[2], 1);
    chk("R9 set wins over clear", err_ovl[2], 1);
    cmd_hi[2] = 1'b0;
    step(20);
    chk("R9 flag sticky", err_ovl[2], 1);

    // R6: immediate hand-over violates dead time
    cmd_lo[0] = 1'b1; step(8);
    cmd_lo[0] = 1'b0; cmd_hi[0] = 1'b1; step(8);
    chk("R6 dead violation blocked", gate_hi[0], 0);
    chk("R6 dead flag", err_dead[0], 1);
    cmd_hi[0] = 1'b0;
    // R6: hand-over with enough low time passes
    step(30);
    cmd_lo[0] = 1'b1; step(8);
    cmd_lo[0] = 1'b0; step(4);
    cmd_hi[0] = 1'b1; step(MIN_ON);
    chk("R6 dead satisfied", gate_hi[0], 1);
    step(2); cmd_hi[0] = 1'b0;

    // R7: second rise too soon
    step(30);
    cmd_hi[1] = 1'b1; step(6);
    chk("R7 first pulse passes", gate_hi[1], 1);
    cmd_hi[1] = 1'b0; step(6);
    cmd_hi[1] = 1'b1; step(6);
    chk("R7 fast pulse blocked", gate_hi[1], 0);
    chk("R7 rate flag", err_rate[1], 1);
    cmd_hi[1] = 1'b0;

    // R5: short low gap
    step(30);
    cmd_hi[2] = 1'b1; step(6);
    cmd_hi[2] = 1'b0; step(2);
    cmd_hi[2] = 1'b1; step(8);
    chk("R5 short gap blocked", gate_hi[2], 0);
    chk("R5 short gap flag", err_width[2], 1);
    cmd_hi[2] = 1'b0;
    step(30);

    // Constrained random traffic compared against the model
    for (int p = 0; p < NPH; p++) hold[p] = 0;
    for (int i = 0; i < 6000; i++) begin
      for (int p = 0; p < NPH; p++) begin
        if (hold[p] == 0) begin
          mode[p] = int'($urandom % 16);
          hold[p] = 1 + int'($urandom % 20);
        end
        hold[p]--;
        cmd_hi[p] = (mode[p] < 6) || (mode[p] == 15);
        cmd_lo[p] = (mode[p] >= 6 && mode[p] < 12) || (mode[p] == 15);
      end
      clr = ($urandom % 97) == 0;
      step(1);
    end
    cmd_hi = '0; cmd_lo = '0; clr = 1'b0;
    step(5);
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule